// File: doc/BRIEF.md
# Owner-Token Backup Line Controller

This block is the per-line state machine a cache controller instantiates for each line that can hold the owner token. It lets an ownership transfer survive the loss of any single coherence message. When the line gives away the owner token with data, it keeps the data as a backup that cannot be read. It keeps that backup until the receiver confirms arrival. A line that receives the owner token may read and write the data at once. It may not pass the owner token on until it hears that the previous holder has deleted its backup.

A single down-counter serves as the watchdog. Depending on the state, it measures either how long a backup has waited for its ownership acknowledgement or how long a replacement of a blocked line has waited. When the counter runs out, the block raises a token recreation request. The block then answers the three recovery messages: set-serial, backup-invalidate and recreation-done.

Inputs are decoded one-cycle event strobes. Outputs are registered one-cycle send strobes and the current line state.

Top module: `owner_backup_line`

## Requirements
- R1: After reset the line is invalid, `line_state` reads 0, `line_readable` is low and every send strobe is low. State codes are: invalid 0, modified 1, backup 2, blocked-modified 3, backup-recreating 4, invalid-recreating 5.
- R2: In state 1, an owner-send request moves the line to state 2 on the next clock and pulses `tx_owner_data` for one cycle. In state 2, `line_readable` is low.
- R3: In state 0 or 5, an arriving owner token with data moves the line to state 3 and pulses `tx_own_ack`. `line_readable` is high in states 1 and 3.
- R4: In state 2, an ownership acknowledgement moves the line to state 0, pulses `tx_bdel_ack` and raises no recreation request.
- R5: In state 3, a backup-deletion acknowledgement moves the line to state 1. An owner-send request in state 3 is refused: no `tx_owner_data` and no state change.
- R6: If a line stays in state 2 for LOST_DATA_CYC clocks after the clock that entered it, `tx_recreate_req` pulses on that clock and the line enters state 4. An acknowledgement arriving on the expiry clock wins.
- R7: A replacement request in state 3 starts a REPL_WAIT_CYC timeout. When it expires, `tx_recreate_req` pulses and the line stays in state 3. A backup-deletion acknowledgement first cancels it. Further replacement requests while it runs do not restart it. Replacement requests in other states have no effect.
- R8: On set-serial, the line pulses `tx_serial_ack`. From state 1 or 3 it goes to 0 and also pulses `tx_serial_ack_data`. In every other state the line keeps its state.
- R9: On backup-invalidate, the line pulses `tx_binv_ack`. A line in state 2 or 4 enters state 5, and other states are unchanged.
- R10: On recreation-done with data, the line enters state 1. Without data, a line in state 2 or 4 enters state 1. A line in state 0 or 5 goes to 0 and pulses `miss_restart`. A line in state 1 or 3 is unchanged.
- R11: Recovery messages take priority over normal events and timeout expiry in the same cycle, in the order set-serial, backup-invalidate, done. A pending expiry is not lost; it is acted on once no recovery message is present.
- R12: At most one of `tx_owner_data`, `tx_own_ack`, `tx_bdel_ack`, `tx_recreate_req`, `tx_serial_ack`, `tx_binv_ack`, `miss_restart` is high in any cycle, and each is a single-cycle pulse per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_owner_req | input | 1 | Request to send data with the owner token |
| ev_owner_in | input | 1 | Owner token with data has arrived |
| ev_own_ack | input | 1 | Ownership acknowledgement arrived |
| ev_bdel_ack | input | 1 | Backup-deletion acknowledgement arrived |
| ev_replace | input | 1 | Line must be replaced |
| ev_set_serial | input | 1 | Recovery set-serial message |
| ev_backup_inv | input | 1 | Recovery backup-invalidate message |
| ev_done | input | 1 | Recovery completion message |
| done_with_data | input | 1 | Completion message carries data |
| line_state | output | 3 | Current state code |
| line_readable | output | 1 | Line holds readable data |
| tx_owner_data | output | 1 | Send data plus owner token |
| tx_own_ack | output | 1 | Send ownership acknowledgement |
| tx_bdel_ack | output | 1 | Send backup-deletion acknowledgement |
| tx_recreate_req | output | 1 | Send token recreation request |
| tx_serial_ack | output | 1 | Acknowledge set-serial |
| tx_serial_ack_data | output | 1 | Set-serial acknowledgement carries data |
| tx_binv_ack | output | 1 | Acknowledge backup-invalidate |
| miss_restart | output | 1 | Restart normal miss handling |

## Verification
The sharpest collision is an ownership acknowledgement arriving on exactly the clock the lost-data counter expires. The same race exists between a backup-deletion acknowledgement and the replacement timeout. The bench sweeps the arrival clock of the acknowledgement from one cycle after entry to one past the limit. For each arrival clock it predicts arithmetically whether recovery is requested. A second collision is a recovery message coinciding with a normal event or a pending expiry. This is provoked by driving both on the same edge and judged by the priority order in R11.

// File: rtl/obl_pkg.sv
package obl_pkg;
  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_M  = 3'd1,
    ST_B  = 3'd2,
    ST_MB = 3'd3,
    ST_BR = 3'd4,
    ST_IR = 3'd5
  } line_st_e;

  typedef struct packed {
    logic owner_data;
    logic own_ack;
    logic bdel_ack;
    logic recreate;
    logic serial_ack;
    logic serial_data;
    logic binv_ack;
    logic restart;
  } tx_s;
endpackage

// File: rtl/obl_timer.sv
module obl_timer #(
  parameter int LOST_DATA_CYC = 6667,
  parameter int REPL_WAIT_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel_repl,
  input  logic stop,
  output logic armed,
  output logic expire
);
  localparam int MAXL = (LOST_DATA_CYC > REPL_WAIT_CYC) ? LOST_DATA_CYC : REPL_WAIT_CYC;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] LD_INIT = CW'(LOST_DATA_CYC - 1);
  localparam logic [CW-1:0] RP_INIT = CW'(REPL_WAIT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          cnt_en;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (load) begin
      cnt_d   = sel_repl ? RP_INIT : LD_INIT;
      armed_d = 1'b1;
    end else if (stop) begin
      armed_d = 1'b0;
    end else if (armed_q && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = load | stop | armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign armed  = armed_q;
  assign expire = armed_q && (cnt_q == '0);

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q <= CW'(MAXL - 1)));

  // R7
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load && !stop) |=> expire);
endmodule

// File: rtl/obl_next.sv
module obl_next
  import obl_pkg::*;
(
  input  line_st_e st,
  input  logic     ev_owner_req,
  input  logic     ev_owner_in,
  input  logic     ev_own_ack,
  input  logic     ev_bdel_ack,
  input  logic     ev_replace,
  input  logic     ev_set_serial,
  input  logic     ev_backup_inv,
  input  logic     ev_done,
  input  logic     done_with_data,
  input  logic     tmr_armed,
  input  logic     tmr_expire,
  output line_st_e nxt,
  output tx_s      tx,
  output logic     tmr_load,
  output logic     tmr_sel_repl,
  output logic     tmr_stop
);
  logic exp_taken;
  logic has_valid, has_backup, no_copy;

  assign has_valid  = (st == ST_M)  || (st == ST_MB);
  assign has_backup = (st == ST_B)  || (st == ST_BR);
  assign no_copy    = (st == ST_I)  || (st == ST_IR);

  always_comb begin
    nxt          = st;
    tx           = '0;
    tmr_load     = 1'b0;
    tmr_sel_repl = 1'b0;
    exp_taken    = 1'b0;
    if (ev_set_serial) begin
      tx.serial_ack = 1'b1;
      if (has_valid) begin
        nxt            = ST_I;
        tx.serial_data = 1'b1;
      end
    end else if (ev_backup_inv) begin
      tx.binv_ack = 1'b1;
      if (has_backup) nxt = ST_IR;
    end else if (ev_done) begin
      if (done_with_data || has_backup) begin
        nxt = ST_M;
      end else if (no_copy) begin
        nxt        = ST_I;
        tx.restart = 1'b1;
      end
    end else begin
      unique case (st)
        ST_M: if (ev_owner_req) begin
          nxt           = ST_B;
          tx.owner_data = 1'b1;
          tmr_load      = 1'b1;
        end
        ST_I, ST_IR: if (ev_owner_in) begin
          nxt        = ST_MB;
          tx.own_ack = 1'b1;
        end
        ST_B: begin
          if (ev_own_ack) begin
            nxt         = ST_I;
            tx.bdel_ack = 1'b1;
          end else if (tmr_expire) begin
            nxt         = ST_BR;
            tx.recreate = 1'b1;
          end
        end
        ST_MB: begin
          if (ev_bdel_ack) begin
            nxt = ST_M;
          end else if (tmr_expire) begin
            tx.recreate = 1'b1;
            exp_taken   = 1'b1;
          end else if (ev_replace && !tmr_armed) begin
            tmr_load     = 1'b1;
            tmr_sel_repl = 1'b1;
          end
        end
        default: ;
      endcase
    end
    tmr_stop = !tmr_load && ((nxt != st) || exp_taken);
  end
endmodule

// File: rtl/owner_backup_line.sv
module owner_backup_line
  import obl_pkg::*;
#(
  parameter int LOST_DATA_CYC = 6667,
  parameter int REPL_WAIT_CYC = 10000,
  parameter int RST_SYNC_LEN  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_owner_req,
  input  logic       ev_owner_in,
  input  logic       ev_own_ack,
  input  logic       ev_bdel_ack,
  input  logic       ev_replace,
  input  logic       ev_set_serial,
  input  logic       ev_backup_inv,
  input  logic       ev_done,
  input  logic       done_with_data,
  output logic [2:0] line_state,
  output logic       line_readable,
  output logic       tx_owner_data,
  output logic       tx_own_ack,
  output logic       tx_bdel_ack,
  output logic       tx_recreate_req,
  output logic       tx_serial_ack,
  output logic       tx_serial_ack_data,
  output logic       tx_binv_ack,
  output logic       miss_restart
);
  logic [RST_SYNC_LEN-1:0] rst_pipe;
  logic                    rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC_LEN-2:0], 1'b1};
  end
  assign rst_ns = rst_pipe[RST_SYNC_LEN-1];

  line_st_e st_q, st_d;
  tx_s      tx_q, tx_d;
  logic     t_load, t_sel, t_stop, t_armed, t_expire;
  logic     st_en, tx_en;

  obl_timer #(
    .LOST_DATA_CYC(LOST_DATA_CYC),
    .REPL_WAIT_CYC(REPL_WAIT_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_ns),
    .load     (t_load),
    .sel_repl (t_sel),
    .stop     (t_stop),
    .armed    (t_armed),
    .expire   (t_expire)
  );

  obl_next u_next (
    .st             (st_q),
    .ev_owner_req   (ev_owner_req),
    .ev_owner_in    (ev_owner_in),
    .ev_own_ack     (ev_own_ack),
    .ev_bdel_ack    (ev_bdel_ack),
    .ev_replace     (ev_replace),
    .ev_set_serial  (ev_set_serial),
    .ev_backup_inv  (ev_backup_inv),
    .ev_done        (ev_done),
    .done_with_data (done_with_data),
    .tmr_armed      (t_armed),
    .tmr_expire     (t_expire),
    .nxt            (st_d),
    .tx             (tx_d),
    .tmr_load       (t_load),
    .tmr_sel_repl   (t_sel),
    .tmr_stop       (t_stop)
  );

  assign st_en = (st_d != st_q);
  assign tx_en = (tx_d != tx_q);

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    st_q <= ST_I;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    tx_q <= '0;
    else if (tx_en) tx_q <= tx_d;
  end

  assign line_state         = st_q;
  assign line_readable      = (st_q == ST_M) || (st_q == ST_MB);
  assign tx_owner_data      = tx_q.owner_data;
  assign tx_own_ack         = tx_q.own_ack;
  assign tx_bdel_ack        = tx_q.bdel_ack;
  assign tx_recreate_req    = tx_q.recreate;
  assign tx_serial_ack      = tx_q.serial_ack;
  assign tx_serial_ack_data = tx_q.serial_data;
  assign tx_binv_ack        = tx_q.binv_ack;
  assign miss_restart       = tx_q.restart;

  // R2
  owner_out_state_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    tx_owner_data |-> (st_q == ST_B) && ($past(st_q) == ST_M));

  // R3
  own_ack_state_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    tx_own_ack |-> (st_q == ST_MB));

  // R4
  bdel_from_backup_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    tx_bdel_ack |-> (st_q == ST_I) && ($past(st_q) == ST_B));

  // R5
  blocked_no_forward_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == ST_MB) |=> (st_q != ST_B) && !tx_owner_data);

  // R8
  serial_data_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    tx_serial_ack_data |-> tx_serial_ack && (st_q == ST_I));

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({tx_owner_data, tx_own_ack, tx_bdel_ack, tx_recreate_req,
              tx_serial_ack, tx_binv_ack, miss_restart}));
endmodule

// File: tb/tb_owner_backup_line.sv
`timescale 1ns/1ps
module tb_owner_backup_line;
  localparam int LD = 5;
  localparam int RP = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic ev_owner_req, ev_owner_in, ev_own_ack, ev_bdel_ack, ev_replace;
  logic ev_set_serial, ev_backup_inv, ev_done, done_with_data;
  logic [2:0] line_state;
  logic line_readable, tx_owner_data, tx_own_ack, tx_bdel_ack, tx_recreate_req;
  logic tx_serial_ack, tx_serial_ack_data, tx_binv_ack, miss_restart;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  owner_backup_line #(.LOST_DATA_CYC(LD), .REPL_WAIT_CYC(RP)) dut (
    .clk(clk), .rst_n(rst_n),
    .ev_owner_req(ev_owner_req), .ev_owner_in(ev_owner_in), .ev_own_ack(ev_own_ack),
    .ev_bdel_ack(ev_bdel_ack), .ev_replace(ev_replace), .ev_set_serial(ev_set_serial),
    .ev_backup_inv(ev_backup_inv), .ev_done(ev_done), .done_with_data(done_with_data),
    .line_state(line_state), .line_readable(line_readable), .tx_owner_data(tx_owner_data),
    .tx_own_ack(tx_own_ack), .tx_bdel_ack(tx_bdel_ack), .tx_recreate_req(tx_recreate_req),
    .tx_serial_ack(tx_serial_ack), .tx_serial_ack_data(tx_serial_ack_data),
    .tx_binv_ack(tx_binv_ack), .miss_restart(miss_restart)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    ev_owner_req = 0; ev_owner_in = 0; ev_own_ack = 0; ev_bdel_ack = 0; ev_replace = 0;
    ev_set_serial = 0; ev_backup_inv = 0; ev_done = 0; done_with_data = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; clr();
  endtask

  task automatic do_reset();
    clr(); rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) tick();
  endtask

  // 0 I, 1 M, 2 B, 3 MB, 4 BR, 5 IR
  task automatic goto_state(input int s);
    do_reset();
    if (s == 0) return;
    if (s == 5) begin
      ev_owner_in = 1; tick(); ev_bdel_ack = 1; tick(); ev_owner_req = 1; tick();
      ev_backup_inv = 1; tick(); return;
    end
    ev_owner_in = 1; tick();
    if (s == 3) return;
    ev_bdel_ack = 1; tick();
    if (s == 1) return;
    ev_owner_req = 1; tick();
    if (s == 2) return;
    repeat (LD) tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 state", line_state, 0);
    chk("R1 readable", line_readable, 0);
    chk("R1 strobes", {tx_owner_data, tx_own_ack, tx_bdel_ack, tx_recreate_req,
        tx_serial_ack, tx_binv_ack, miss_restart}, 0);

    // R3 owner arrives in I
    ev_owner_in = 1; tick();
    chk("R3 state", line_state, 3);
    chk("R3 ack", tx_own_ack, 1);
    chk("R3 readable", line_readable, 1);
    // R5 owner request refused in MB
    ev_owner_req = 1; tick();
    chk("R5 refuse tx", tx_owner_data, 0);
    chk("R5 refuse state", line_state, 3);
    chk("R12 single pulse", tx_own_ack, 0);
    ev_bdel_ack = 1; tick();
    chk("R5 to M", line_state, 1);
    // R2
    ev_owner_req = 1; tick();
    chk("R2 state", line_state, 2);
    chk("R2 tx", tx_owner_data, 1);
    chk("R2 readable", line_readable, 0);
    tick();
    chk("R12 tx drop", tx_owner_data, 0);

    // R6 / R4 sweep: ack k clocks after entry edge
    for (int k = 1; k <= LD + 2; k++) begin
      int seen_rec;
      goto_state(1);
      ev_owner_req = 1; tick();
      seen_rec = 0;
      for (int c = 1; c < k; c++) begin
        tick();
        if (tx_recreate_req) begin
          seen_rec = 1;
          chk("R6 recreate clock", c, LD);
          chk("R6 to BR", line_state, 4);
        end
      end
      ev_own_ack = 1; tick();
      if (k <= LD) begin
        chk("R4 bdel", tx_bdel_ack, 1);
        chk("R4 state", line_state, 0);
        chk("R4 no recreate", tx_recreate_req | seen_rec, 0);
      end else begin
        chk("R6 recreated", seen_rec, 1);
        chk("R6 ack ignored in BR", line_state, 4);
      end
    end

    // R7 sweep: bdel ack j clocks after replace
    for (int j = 1; j <= RP + 2; j++) begin
      int rec_at;
      goto_state(3);
      ev_replace = 1; tick();
      rec_at = 0;
      for (int c = 1; c < j; c++) begin
        if (c == 2) ev_replace = 1;
        tick();
        if (tx_recreate_req) rec_at = c;
      end
      ev_bdel_ack = 1; tick();
      if (j <= RP) begin
        chk("R7 cancelled", rec_at | tx_recreate_req, 0);
        chk("R7 to M", line_state, 1);
      end else begin
        chk("R7 expiry clock", rec_at, RP);
        chk("R7 to M after", line_state, 1);
      end
    end
    // R7 replace in M has no effect
    goto_state(1);
    ev_replace = 1; tick();
    begin
      int r;
      r = 0;
      for (int c = 0; c < RP + 3; c++) begin tick(); r |= tx_recreate_req; end
      chk("R7 replace in M", r, 0);
      chk("R7 M kept", line_state, 1);
    end

    // R8 R9 R10 recovery sweep over all states
    for (int s = 0; s < 6; s++) begin
      for (int m = 0; m < 4; m++) begin
        int exp_st, valid, bk, nc;
        goto_state(s);
        valid = (s == 1 || s == 3);
        bk    = (s == 2 || s == 4);
        nc    = (s == 0 || s == 5);
        case (m)
          0: ev_set_serial = 1;
          1: ev_backup_inv = 1;
          2: ev_done = 1;
          default: begin ev_done = 1; done_with_data = 1; end
        endcase
        tick();
        if (m == 0) begin
          exp_st = valid ? 0 : s;
          chk("R8 ack", tx_serial_ack, 1);
          chk("R8 data", tx_serial_ack_data, valid);
          chk("R8 state", line_state, exp_st);
        end else if (m == 1) begin
          exp_st = bk ? 5 : s;
          chk("R9 ack", tx_binv_ack, 1);
          chk("R9 state", line_state, exp_st);
        end else if (m == 2) begin
          exp_st = bk ? 1 : (nc ? 0 : s);
          chk("R10 nodata state", line_state, exp_st);
          chk("R10 restart", miss_restart, nc);
        end else begin
          chk("R10 data state", line_state, 1);
          chk("R10 no restart", miss_restart, 0);
        end
      end
    end

    // R11 priority: set-serial with own ack in B
    goto_state(2);
    ev_set_serial = 1; ev_own_ack = 1; tick();
    chk("R11 B kept", line_state, 2);
    chk("R11 no bdel", tx_bdel_ack, 0);
    // R11 owner request with set-serial in M
    goto_state(1);
    ev_owner_req = 1; ev_set_serial = 1; tick();
    chk("R11 M to I", line_state, 0);
    chk("R11 no owner tx", tx_owner_data, 0);
    chk("R11 data ack", tx_serial_ack_data, 1);
    // R11 expiry deferred by set-serial then acted on
    goto_state(1);
    ev_owner_req = 1; tick();
    repeat (LD - 1) tick();
    ev_set_serial = 1; tick();
    chk("R11 deferred no rec", tx_recreate_req, 0);
    chk("R11 deferred state", line_state, 2);
    tick();
    chk("R11 deferred rec", tx_recreate_req, 1);
    chk("R11 deferred BR", line_state, 4);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule